// File: doc/BRIEF.md
# Time-Shared Eight-Channel Sine Synthesizer

This block generates eight independent sine waves from a single shared sine lookup table. Each channel keeps its own 32-bit phase accumulator and its own frequency tuning word. A slot counter steps through the channels in a fixed round-robin order, one channel per clock. In each slot, the selected channel's phase is turned into an amplitude, and that channel's accumulator then advances by its tuning word. At a 16 MHz core clock, each channel produces one sample every eight cycles, which gives 2 MHz per channel.

Only a quarter of a sine period is stored. The table is computed at elaboration from the phase and amplitude widths, using rounded ideal values. The two top phase bits choose whether the address is mirrored and whether the result is negated. The amplitude range is symmetric about zero, so a full period adds up to no DC offset.

Software sets the tuning words through a one-cycle write strobe. Each output sample carries a channel tag and a valid pulse. The delay from phase to output is a fixed three cycles, and no parameter changes it.

Top module: `mc_sine_synth`

## Requirements
- R1: After reset is released, the first slot serves channel 0. The slots then continue 1, 2, … 7, 0 without gaps. Once the pipeline has filled, `out_valid` is high on every cycle, and `out_ch` goes up by one (modulo 8) from each valid sample to the next.
- R2: In each slot, the channel's accumulator value is used first and then advanced by that channel's tuning word (modulo 2^32). The table phase index is `acc[31:20]`, and bits 19:0 are dropped.
- R3: For phase index p (0..4095), `out_sample` is round(32767·sin(2π(p+0.5)/4096)) in two's complement. Rounding goes half away from zero. Index bits 11:10 select the quadrant: 0 reads the table directly, 1 reads it mirrored, 2 reads it directly and negates, and 3 reads it mirrored and negates.
- R4: The output range is symmetric: the largest value is +32767 and the smallest is −32767. The value −32768 is never produced.
- R5: A pulse on `wr_en` stores `wr_ftw` as the tuning word of channel `wr_ch` at that clock edge. If the slot at that same edge belongs to the written channel, that update still uses the old word. Every later update uses the new word.
- R6: When `phase_clr[c]` is high at a clock edge, accumulator c is zero after that edge. The clear overrides the advance.
- R7: A slot that is processed at clock edge E shows up on the outputs right after edge E+2. The latency is therefore three edges, and `out_ch` and `out_valid` stay aligned with the sample.
- R8: Synchronous reset drives `out_valid` low and sets all accumulators and tuning words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Tuning word write strobe |
| wr_ch | input | 3 | Channel to write |
| wr_ftw | input | 32 | New tuning word |
| phase_clr | input | 8 | Per-channel accumulator clear |
| out_valid | output | 1 | Sample valid pulse |
| out_ch | output | 3 | Channel of the current sample |
| out_sample | output | 16 | Signed sine sample |

## Verification
A wrong accumulator or tuning word causes a wrong value for that channel at its next slot's output, three cycles after that slot. Each channel's error therefore appears within eleven cycles. A wrong table entry or a wrong mirroring or negation only shows when the phase reaches the affected region. For that reason one channel sweeps all 4096 phase indices, and others step by exact quarter periods to hit the peaks. A slot counter that drifts shows up immediately as a channel tag out of order against the scoreboard.

// File: rtl/mc_sine_synth.sv
module mc_sine_synth #(
  parameter int NCH    = 8,
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(NCH)-1:0]  wr_ch,
  input  logic [ACC_W-1:0]        wr_ftw,
  input  logic [NCH-1:0]          phase_clr,
  output logic                    out_valid,
  output logic [$clog2(NCH)-1:0]  out_ch,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int CH_W   = $clog2(NCH);
  localparam int QA_W   = ADDR_W - 2;
  localparam int QDEPTH = 1 << QA_W;
  localparam int QW     = OUT_W - 1;
  localparam real AMP   = real'((1 << (OUT_W - 1)) - 1);

  function automatic real taylor_sin(real x);
    real term, acc_s;
    term  = x;
    acc_s = x;
    for (int n = 1; n < 10; n++) begin
      term  = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc_s = acc_s + term;
    end
    return acc_s;
  endfunction

  function automatic int quarter_val(int k);
    real ang;
    ang = 6.283185307179586 * (real'(k) + 0.5) / real'(4 * QDEPTH);
    return $rtoi(AMP * taylor_sin(ang) + 0.5);
  endfunction

  logic [QW-1:0] qtab [QDEPTH];
  for (genvar k = 0; k < QDEPTH; k++) begin : g_tab
    assign qtab[k] = QW'(quarter_val(k));
  end

  logic [CH_W-1:0]  slot;
  logic [ACC_W-1:0] acc [NCH];
  logic [ACC_W-1:0] ftw [NCH];

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= CH_W'(slot + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) ftw[i] <= '0;
    end else if (wr_en) begin
      ftw[wr_ch] <= wr_ftw;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst || phase_clr[g])    acc[g] <= '0;
      else if (slot == CH_W'(g))  acc[g] <= acc[g] + ftw[g];
    end

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
      phase_clr[g] |=> acc[g] == '0);
  end

  logic              s1_vld, s2_vld, s2_neg;
  logic [CH_W-1:0]   s1_ch, s2_ch;
  logic [ADDR_W-1:0] s1_ph;
  logic [QW-1:0]     s2_mag;
  logic [QA_W-1:0]   q_addr;

  assign q_addr = s1_ph[ADDR_W-2] ? ~s1_ph[QA_W-1:0] : s1_ph[QA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0; s1_ch <= '0; s1_ph <= '0;
      s2_vld <= 1'b0; s2_ch <= '0; s2_neg <= 1'b0; s2_mag <= '0;
      out_valid <= 1'b0; out_ch <= '0; out_sample <= '0;
    end else begin
      s1_vld <= 1'b1;
      s1_ch  <= slot;
      s1_ph  <= acc[slot][ACC_W-1 -: ADDR_W];
      s2_vld <= s1_vld;
      s2_ch  <= s1_ch;
      s2_neg <= s1_ph[ADDR_W-1];
      s2_mag <= qtab[q_addr];
      out_valid  <= s2_vld;
      out_ch     <= s2_ch;
      out_sample <= s2_neg ? -$signed({1'b0, s2_mag}) : $signed({1'b0, s2_mag});
    end
  end

  p_rr_order_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(out_valid) |-> out_ch == CH_W'($past(out_ch) + 1'b1));

  p_no_min_code_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sample != {1'b1, {(OUT_W-1){1'b0}}});

  p_ftw_store_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ftw[$past(wr_ch)] == $past(wr_ftw));

  p_fixed_latency_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_vld, 2));
endmodule

// File: tb/mc_sine_synth_tb.sv
module mc_sine_synth_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_ch = '0;
  logic [31:0] wr_ftw = '0;
  logic [7:0]  phase_clr = '0;
  logic        out_valid;
  logic [2:0]  out_ch;
  logic signed [15:0] out_sample;

  always #5 clk = ~clk;

  mc_sine_synth dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_ftw(wr_ftw),
    .phase_clr(phase_clr), .out_valid(out_valid), .out_ch(out_ch),
    .out_sample(out_sample)
  );

  int checks = 0, fails = 0, cyc = 0;
  int q_ch[$], q_val[$], q_stamp[$];
  string q_tag[$];
  string cur_tag = "R3";
  logic [31:0] acc_m [8];
  logic [31:0] ftw_m [8];
  int m_slot = 0;
  int seen_max = -100000, seen_min = 100000;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ideal(logic [31:0] ph);
    real x;
    x = 32767.0 * $sin(6.283185307179586 * (real'(ph[31:20]) + 0.5) / 4096.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    if (rst) begin
      for (int g = 0; g < 8; g++) begin acc_m[g] = '0; ftw_m[g] = '0; end
      m_slot = 0;
    end else begin
      q_ch.push_back(m_slot);
      q_val.push_back(ideal(acc_m[m_slot]));
      q_stamp.push_back(cyc);
      q_tag.push_back(cur_tag);
      for (int g = 0; g < 8; g++)
        if (phase_clr[g]) acc_m[g] = '0;
        else if (g == m_slot) acc_m[g] = acc_m[g] + ftw_m[g];
      if (wr_en) ftw_m[wr_ch] = wr_ftw;
      m_slot = (m_slot + 1) % 8;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int ch, logic [31:0] v);
    wr_en = 1'b1; wr_ch = 3'(ch); wr_ftw = v;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      if (out_valid) begin
        if (q_ch.size() == 0) begin
          check(0, "R7", 1, 0);
        end else begin
          int ech, ev, es;
          string t;
          ech = q_ch.pop_front(); ev = q_val.pop_front();
          es = q_stamp.pop_front(); t = q_tag.pop_front();
          check(int'(out_ch) == ech, "R1", int'(out_ch), ech);
          check(int'(out_sample) == ev, t, int'(out_sample), ev);
          check(cyc - es == 3, "R7", cyc - es, 3);
          if (int'(out_sample) > seen_max) seen_max = int'(out_sample);
          if (int'(out_sample) < seen_min) seen_min = int'(out_sample);
        end
      end
    end
  end

  initial begin : driver
    for (int g = 0; g < 8; g++) begin acc_m[g] = '0; ftw_m[g] = '0; end
    @(negedge clk);
    run(4);
    check(out_valid == 1'b0, "R8", int'(out_valid), 0);
    rst = 1'b0;
    tick();
    check(out_valid == 1'b0, "R8", int'(out_valid), 0);
    cur_tag = "R8";
    run(15);
    cur_tag = "R5";
    wr(0, 32'h4000_0000);
    wr(1, 32'h0010_0000);
    wr(2, 32'h0123_4567);
    wr(3, 32'hFFFF_F000);
    wr(4, 32'h8000_0000);
    wr(5, 32'h00AB_CDEF);
    wr(6, 32'h3FFF_FFFF);
    wr(7, 32'h0FED_CBA9);
    cur_tag = "R2";
    run(400);
    cur_tag = "R6";
    phase_clr = 8'b0000_0100;
    run(5);
    phase_clr = 8'b1000_0001;
    tick();
    phase_clr = '0;
    run(100);
    cur_tag = "R5";
    while (m_slot != 5) tick();
    wr(5, 32'h0200_0000);
    run(60);
    cur_tag = "R3";
    phase_clr = 8'b0000_0010;
    tick();
    phase_clr = '0;
    run(4096 * 8 + 16);
    check(seen_max == 32767, "R4", seen_max, 32767);
    check(seen_min == -32767, "R4", seen_min, -32767);
    check(q_ch.size() <= 3, "R7", q_ch.size(), 3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule